// File: doc/BRIEF.md
# Subranging Converter Digital Correction

This block turns the raw comparator decisions of a three-pass subranging analog-to-digital converter into one 12-bit output code. A six-comparator coarse estimator fixes where a 16-comparator window sits on the upper ladder. The same 16-comparator bank then fires three times: a coarse pass inside that window, a fine pass on the 16 taps of the fine ladder, and a last pass. The last pass spans the selected fine interval plus six spare steps on each side, so small analog errors can be corrected digitally.

Each input word is a thermometer code. It is converted by counting its ones, so a stray bubble costs at most one step and never a large jump. The coarse window is placed in half-window groups of 8 taps, so it overlaps the estimator's ranges. A coarse result in the lower half of an odd-numbered window therefore lowers the estimator's two-bit section by one. Overflow of the fine pass and the signed offset of the last pass are folded into the upper bits. The result is clamped to the 12-bit range. Each pass has its own strobe. The window selection is available for the ladder switches as soon as the estimator strobe has been taken.

Top module: `tsc_digital_correct`

## Requirements
- R1: Every thermometer word is reduced to the number of ones it contains, whatever their positions. A word with bubbles, such as 16'b0000_0000_0101_0111, counts as 5.
- R2: On a clock edge with `est_vld` high, `win_grp` takes the ones count E of `est_therm` (0..6). From the following cycle `est_sec` shows (E+1)>>1, so 6'b000111 gives `win_grp`=3 and `est_sec`=2.
- R3: The estimator count, the coarse count N1 and the fine count N2 are captured only on edges where `est_vld`, `p1_vld` or `p2_vld` is high, respectively. Strobes of the first two passes without a third-pass strobe leave `code` and `code_vld` untouched. The captured values persist into later conversions.
- R4: The 6-bit coarse value is 8*E+N1. When E is odd and N1<8, code bits [11:10] equal `est_sec`-1 (a lowered estimate). With E=3 and N1=5, bits [11:10] are 01.
- R5: The 10-bit value is 16*(8*E+N1)+N2, with N2 in 0..16. A count of 16 carries into the coarse field.
- R6: The last-pass count N3 (0..16) adds N3-6. Counts 6..9 stay inside the fine interval, counts below 6 borrow from the 10-bit value, and counts above 9 carry into it.
- R7: `code` = 4*(16*(8*E+N1)+N2)+N3-6, clamped to 0 when negative and to 4095 when above 4095.
- R8: `code` is loaded on each edge with `p3_vld` high, using `flash_therm` at that edge. `code_vld` is high for exactly the cycle after that edge, and `code` holds until the next third-pass strobe.
- R9: While `rst_n` is low, `code`, `code_vld`, `win_grp` and `est_sec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| est_vld | input | 1 | Capture strobe for the estimator word |
| est_therm | input | 6 | Coarse estimator thermometer word |
| p1_vld | input | 1 | Capture strobe for the coarse pass |
| p2_vld | input | 1 | Capture strobe for the fine pass |
| p3_vld | input | 1 | Capture strobe for the last pass; starts the output update |
| flash_therm | input | 16 | Shared 16-comparator thermometer word |
| win_grp | output | 3 | Window position in 8-tap groups (estimator ones count) |
| est_sec | output | 2 | Estimator two-bit section index |
| code | output | 12 | Corrected conversion result |
| code_vld | output | 1 | One-cycle flag for a new result |

## Verification
The bench targets the overlap decrement. It uses an odd estimator count with a low coarse count; a design that kept the estimator section would put 10 instead of 01 in the top bits. It drives last-pass counts of 2, 6, 9 and 14 against a fixed fine value, which exposes a wrong margin or a dropped borrow or carry as an offset of several steps. Other cases cover a fine count of 16, both clamp limits, and bubbled words, which a highest-bit decoder would misread by two or more steps. Partial strobe sequences check that only the addressed count moves and that `code` and `code_vld` stay untouched.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  // Coarse position on the upper ladder in steps of 1/64 full scale.
  function automatic int coarse_val(int est_ones, int n1, int grp);
    return grp * est_ones + n1;
  endfunction

  // Fine value: coarse value shifted by the fine field plus fine count.
  function automatic int fine_val(int coarse, int n2, int fine_b);
    return (coarse << fine_b) + n2;
  endfunction

  // Final signed value before clamping: the last pass is offset by its margin.
  function automatic int raw_code(int fine, int n3, int last_b, int margin);
    return (fine << last_b) + n3 - margin;
  endfunction

endpackage

// File: rtl/tsc_therm_count.sv
module tsc_therm_count #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  therm,
  output logic [CW-1:0] ones
);

  logic [CW-1:0] part [W+1];

  assign part[0] = '0;

  // Prefix chain: each stage adds one comparator, bubbles included.
  for (genvar gi = 0; gi < W; gi++) begin : g_acc
    assign part[gi+1] = part[gi] + CW'(therm[gi]);
  end

  assign ones = part[W];

endmodule

// File: rtl/tsc_pass_regs.sv
module tsc_pass_regs #(
  parameter int CE_W = 3,
  parameter int FC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            est_vld,
  input  logic [CE_W-1:0] est_ones,
  input  logic            p1_vld,
  input  logic            p2_vld,
  input  logic [FC_W-1:0] fl_ones,
  output logic [CE_W-1:0] ce_q,
  output logic [FC_W-1:0] n1_q,
  output logic [FC_W-1:0] n2_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= '0;
      n1_q <= '0;
      n2_q <= '0;
    end else begin
      if (est_vld) ce_q <= est_ones;
      if (p1_vld)  n1_q <= fl_ones;
      if (p2_vld)  n2_q <= fl_ones;
    end
  end

  AST_EST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !est_vld |=> $stable(ce_q)); // R3
  AST_P1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !p1_vld |=> $stable(n1_q)); // R3
  AST_P2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !p2_vld |=> $stable(n2_q)); // R3

endmodule

// File: rtl/tsc_merge.sv
module tsc_merge #(
  parameter int GRP    = 8,
  parameter int FINE_B = 4,
  parameter int LAST_B = 2,
  parameter int MARGIN = 6,
  parameter int CE_W   = 3,
  parameter int FC_W   = 5,
  parameter int SEC_W  = 2,
  parameter int OUT_W  = 12
) (
  input  logic [CE_W-1:0]  ce,
  input  logic [FC_W-1:0]  n1,
  input  logic [FC_W-1:0]  n2,
  input  logic [FC_W-1:0]  n3,
  input  logic [SEC_W-1:0] sec,
  output logic [OUT_W-1:0] code_next,
  output logic             est_dec,
  output logic             fin_borrow,
  output logic             fin_carry,
  output logic             sat_hi,
  output logic             sat_lo
);

  localparam int COARSE_W = OUT_W - FINE_B - LAST_B;
  localparam int TOP_CODE = (1 << OUT_W) - 1;
  localparam int IN_TOP   = MARGIN + (1 << LAST_B) - 1;

  int coarse, fine, raw;

  always_comb begin
    coarse = tsc_pkg::coarse_val(int'(ce), int'(n1), GRP);
    fine   = tsc_pkg::fine_val(coarse, int'(n2), FINE_B);
    raw    = tsc_pkg::raw_code(fine, int'(n3), LAST_B, MARGIN);
  end

  // Named events for the checks below.
  assign est_dec    = ce[0] && (int'(n1) < GRP);
  assign fin_borrow = int'(n3) < MARGIN;
  assign fin_carry  = int'(n3) > IN_TOP;
  assign sat_lo     = raw < 0;
  assign sat_hi     = raw > TOP_CODE;

  always_comb begin
    if (sat_lo)      code_next = '0;
    else if (sat_hi) code_next = '1;
    else             code_next = OUT_W'(raw);
  end

  always_comb begin
    if (est_dec) begin
      AST_DEC_TOP: assert (((coarse >> (COARSE_W - 2)) & 3) == int'(sec) - 1); // R4
    end
    if (fin_borrow && !sat_lo) begin
      AST_BORROW_DOWN: assert (int'(code_next) < (fine << LAST_B)); // R6
    end
    if (fin_carry && !sat_hi) begin
      AST_CARRY_UP: assert (int'(code_next) >= ((fine + 1) << LAST_B)); // R6
    end
  end

endmodule

// File: rtl/tsc_digital_correct.sv
module tsc_digital_correct #(
  parameter  int EST_N    = 6,
  parameter  int FLASH_N  = 16,
  parameter  int MARGIN   = 6,
  parameter  int COARSE_B = 6,
  localparam int CE_W     = $clog2(EST_N + 1),
  localparam int FC_W     = $clog2(FLASH_N + 1),
  localparam int SEC_W    = CE_W - 1,
  localparam int FINE_B   = $clog2(FLASH_N),
  localparam int LAST_B   = $clog2(FLASH_N - 2 * MARGIN),
  localparam int OUT_W    = COARSE_B + FINE_B + LAST_B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               est_vld,
  input  logic [EST_N-1:0]   est_therm,
  input  logic               p1_vld,
  input  logic               p2_vld,
  input  logic               p3_vld,
  input  logic [FLASH_N-1:0] flash_therm,
  output logic [CE_W-1:0]    win_grp,
  output logic [SEC_W-1:0]   est_sec,
  output logic [OUT_W-1:0]   code,
  output logic               code_vld
);

  localparam int GRP = FLASH_N / 2;

  logic [CE_W-1:0]  est_ones, ce_q;
  logic [FC_W-1:0]  fl_ones, n1_q, n2_q;
  logic [CE_W:0]    sec_sum;
  logic [OUT_W-1:0] code_next;
  logic             est_dec, fin_borrow, fin_carry, sat_hi, sat_lo;

  tsc_therm_count #(.W(EST_N), .CW(CE_W)) u_est_cnt (
    .therm (est_therm),
    .ones  (est_ones)
  );

  tsc_therm_count #(.W(FLASH_N), .CW(FC_W)) u_fl_cnt (
    .therm (flash_therm),
    .ones  (fl_ones)
  );

  tsc_pass_regs #(.CE_W(CE_W), .FC_W(FC_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .est_vld  (est_vld),
    .est_ones (est_ones),
    .p1_vld   (p1_vld),
    .p2_vld   (p2_vld),
    .fl_ones  (fl_ones),
    .ce_q     (ce_q),
    .n1_q     (n1_q),
    .n2_q     (n2_q)
  );

  assign sec_sum = {1'b0, ce_q} + 1'b1;
  assign est_sec = SEC_W'(sec_sum >> 1);
  assign win_grp = ce_q;

  tsc_merge #(
    .GRP(GRP), .FINE_B(FINE_B), .LAST_B(LAST_B), .MARGIN(MARGIN),
    .CE_W(CE_W), .FC_W(FC_W), .SEC_W(SEC_W), .OUT_W(OUT_W)
  ) u_merge (
    .ce         (ce_q),
    .n1         (n1_q),
    .n2         (n2_q),
    .n3         (fl_ones),
    .sec        (est_sec),
    .code_next  (code_next),
    .est_dec    (est_dec),
    .fin_borrow (fin_borrow),
    .fin_carry  (fin_carry),
    .sat_hi     (sat_hi),
    .sat_lo     (sat_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code     <= '0;
      code_vld <= 1'b0;
    end else begin
      code_vld <= p3_vld;
      if (p3_vld) code <= code_next;
    end
  end

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !p3_vld |=> $stable(code)); // R8
  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && !p3_vld) |=> !code_vld); // R8
  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !est_vld |=> $stable(win_grp)); // R2

endmodule

// File: tb/tsc_digital_correct_bench.sv
module tsc_digital_correct_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        est_vld, p1_vld, p2_vld, p3_vld;
  logic [5:0]  est_therm;
  logic [15:0] flash_therm;
  logic [2:0]  win_grp;
  logic [1:0]  est_sec;
  logic [11:0] code;
  logic        code_vld;

  int total = 0;
  int bad   = 0;
  int last_code;

  always #10 clk = ~clk;

  tsc_digital_correct u_tsc_digital_correct (
    .clk         (clk),
    .rst_n       (rst_n),
    .est_vld     (est_vld),
    .est_therm   (est_therm),
    .p1_vld      (p1_vld),
    .p2_vld      (p2_vld),
    .p3_vld      (p3_vld),
    .flash_therm (flash_therm),
    .win_grp     (win_grp),
    .est_sec     (est_sec),
    .code        (code),
    .code_vld    (code_vld)
  );

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ones(logic [15:0] w);
    int c = 0;
    for (int i = 0; i < 16; i++) if (w[i]) c++;
    return c;
  endfunction

  function automatic logic [15:0] therm(int n);
    logic [16:0] t;
    t = (17'd1 << n) - 17'd1;
    return t[15:0];
  endfunction

  // Expected result written from the requirement: weights 512, 64, 4, 1.
  function automatic int expect_code(int e, int a, int b, int c);
    int acc;
    acc = e * 512 + a * 64 + b * 4 + c - 6;
    if (acc < 0) acc = 0;
    if (acc > 4095) acc = 4095;
    return acc;
  endfunction

  task automatic convert(logic [5:0] e, logic [15:0] w1, logic [15:0] w2,
                         logic [15:0] w3, string req);
    int ce;
    ce = ones({10'd0, e});
    @(negedge clk);
    est_therm = e; est_vld = 1'b1;
    @(negedge clk);
    est_vld = 1'b0;
    check("R2 win_grp", int'(win_grp), ce);
    check("R2 est_sec", int'(est_sec), (ce + 1) / 2);
    flash_therm = w1; p1_vld = 1'b1;
    @(negedge clk);
    p1_vld = 1'b0; p2_vld = 1'b1; flash_therm = w2;
    @(negedge clk);
    p2_vld = 1'b0; p3_vld = 1'b1; flash_therm = w3;
    @(negedge clk);
    p3_vld = 1'b0; flash_therm = 16'($urandom);
    check("R8 valid pulse", int'(code_vld), 1);
    check(req, int'(code), expect_code(ce, ones(w1), ones(w2), ones(w3)));
    last_code = int'(code);
    @(negedge clk);
    check("R8 valid drop", int'(code_vld), 0);
    check("R8 code hold", int'(code), last_code);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; est_vld = 1'b0; p1_vld = 1'b0; p2_vld = 1'b0; p3_vld = 1'b0;
    est_therm = '0; flash_therm = '0;
    repeat (3) @(negedge clk);
    check("R9 code", int'(code), 0);
    check("R9 valid", int'(code_vld), 0);
    check("R9 win_grp", int'(win_grp), 0);
    check("R9 est_sec", int'(est_sec), 0);
    rst_n = 1'b1;

    // R4 lowered estimate: E=3, N1=5 -> coarse 29, top bits 01.
    convert(6'b000111, therm(5), therm(10), therm(8), "R4 R7 lowered");
    check("R4 top bits", int'(code[11:10]), 1);
    // E=4, N1=3 -> coarse 35, top bits kept at 2.
    convert(6'b001111, therm(3), therm(2), therm(7), "R4 kept");
    check("R4 top bits kept", int'(code[11:10]), 2);
    // R6 last pass around a fixed fine value (E=2, N1=8, N2=0).
    convert(6'b000011, therm(8), therm(0), therm(2), "R6 borrow");
    convert(6'b000011, therm(8), therm(0), therm(6), "R6 low edge");
    convert(6'b000011, therm(8), therm(0), therm(9), "R6 high edge");
    convert(6'b000011, therm(8), therm(0), therm(14), "R6 carry");
    // R5 fine count 16 carries into the coarse field.
    convert(6'b000001, therm(4), therm(16), therm(6), "R5 fine carry");
    // R7 clamps.
    convert(6'b000000, therm(0), therm(0), therm(0), "R7 low clamp");
    convert(6'b111111, therm(16), therm(16), therm(16), "R7 high clamp");
    // R1 bubbled words.
    convert(6'b010101, 16'h00F3, 16'h0A0F, 16'b0000_0000_0101_0111, "R1 bubbles");

    // R3 strobes of the first two passes alone leave the output untouched.
    @(negedge clk);
    p1_vld = 1'b1; flash_therm = therm(3);
    @(negedge clk);
    p1_vld = 1'b0; p2_vld = 1'b1; flash_therm = therm(7);
    @(negedge clk);
    p2_vld = 1'b0; flash_therm = 16'hFFFF;
    check("R3 no valid", int'(code_vld), 0);
    check("R3 code untouched", int'(code), last_code);
    p3_vld = 1'b1; flash_therm = therm(6);
    @(negedge clk);
    p3_vld = 1'b0;
    check("R3 retained estimator", int'(code), expect_code(3, 3, 7, 6));

    for (int k = 0; k < 300; k++) begin
      if (k % 2 == 0)
        convert(6'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                "R1 R7 random");
      else
        convert(6'(therm($urandom_range(6, 0))), therm($urandom_range(16, 0)),
                therm($urandom_range(16, 0)), therm($urandom_range(16, 0)),
                "R5 R6 R7 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule